// File: doc/BRIEF.md
# UART Transmit Holding Path

This block sits between the processor bus and the bit serializer of a 16550-class UART. The processor writes bytes to the transmit data address. The serializer collects them one at a time through a valid/pop handshake. The data register is write-only, so the block has no read path back to the processor. A write counts only while the register-bank select input is low. When that input is high, the same address belongs to the baud divisor bank.

A mode input selects how bytes are held. With queueing off, the block holds a single byte, and a new write replaces a byte that has not yet been sent. With queueing on, the block is a 16-entry first-in first-out queue. A write to a full queue is thrown away, unless a pop takes place in the same cycle. A holding-empty flag tells software when nothing is waiting. A change of mode clears whatever is held.

Top module: `uart_tx_hold`

## Requirements
- R1: Once reset has been released, `hold_empty` is 1 and `tx_valid` is 0.
- R2: A write made while `bank_sel` is 1 is ignored. Nothing is stored and `hold_empty` does not change.
- R3: With `fifo_on` at 0, a write stores its byte whether or not a byte is already waiting. An earlier byte that has not been popped is lost, and `tx_data` shows the newest byte.
- R4: With `fifo_on` at 1, up to 16 bytes are held, and they leave through `tx_data` in the order they were written.
- R5: With `fifo_on` at 1 and 16 bytes held, a write with no pop in the same cycle is dropped, and the queued bytes stay unchanged.
- R6: With `fifo_on` at 1 and the queue full, a write and a pop in the same cycle are both accepted, and the queue stays full.
- R7: `hold_empty` is 1 exactly when no byte is held (single mode) or the queue is empty (queue mode), and `tx_valid` is its inverse.
- R8: A cycle in which `fifo_on` differs from its value in the previous cycle empties the block. Any write or pop in that cycle is ignored.
- R9: A `tx_pop` while `tx_valid` is 0 has no effect.
- R10: A pop removes exactly one byte at the clock edge. Outputs reflect the new state in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_on | input | 1 | 1 selects the 16-entry queue, 0 selects the single holding byte |
| bank_sel | input | 1 | Register-bank select; writes are honoured only while this is 0 |
| cpu_wr | input | 1 | Write strobe for the transmit data address |
| cpu_wdata | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Serializer takes the oldest byte |
| tx_valid | output | 1 | A byte is available on tx_data |
| tx_data | output | 8 | Oldest held byte |
| hold_empty | output | 1 | Nothing is waiting to be sent |

## Verification
The hardest state to reach from the ports is a full queue that receives a write and a pop in the same cycle. The bench first fills the queue to 16 entries, then offers one more write on its own to show that it is dropped. Next it drives a write and a pop together and confirms that the queue still drains exactly 16 bytes in order, with the new byte last. A mode flip while bytes are still pending is also applied, together with a write in the same cycle, to show that both the stored bytes and that write are discarded.

// File: rtl/uth_pkg.sv
package uth_pkg;
  localparam int unsigned UTH_DATA_W = 8;
  localparam int unsigned UTH_DEPTH  = 16;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_QUEUE  = 1'b1
  } uth_mode_e;
endpackage

// File: rtl/uth_single.sv
module uth_single #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic              valid,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] hold_q;
  logic              full_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      full_q <= 1'b0;
    end else if (wr) begin
      full_q <= 1'b1;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !flush) hold_q <= wdata;
  end

  assign valid = full_q;
  assign rdata = hold_q;

  assert_overwrite_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && !flush) |=> (valid && rdata == $past(wdata)));

  assert_pop_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && !wr && !flush) |=> !valid);
endmodule

// File: rtl/uth_fifo.sv
module uth_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic              valid,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              full, pop_ok, wr_ok;

  assign full   = (cnt == FULL_CNT);
  assign valid  = (cnt != '0);
  assign pop_ok = pop && valid && !flush;
  assign wr_ok  = wr && !flush && (!full || pop_ok);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ok)  wr_ptr <= bump(wr_ptr);
      if (pop_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (full && wr && !pop && !flush) |=> (full && $stable(wr_ptr) && $stable(rd_ptr)));

  assert_full_wrpop_R6: assert property (@(posedge clk) disable iff (rst)
    (full && wr && pop && !flush) |=> full);

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
    (!valid && pop && !wr) |=> (!valid && $stable(rd_ptr)));
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = uth_pkg::UTH_DATA_W,
  parameter int unsigned DEPTH  = uth_pkg::UTH_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_on,
  input  logic              bank_sel,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              tx_pop,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              hold_empty
);
  import uth_pkg::*;

  uth_mode_e         mode, mode_q;
  logic              flush, wr_g, pop_g;
  logic              s_valid, q_valid;
  logic [DATA_W-1:0] s_data, q_data;

  assign mode = fifo_on ? MODE_QUEUE : MODE_SINGLE;

  always_ff @(posedge clk) begin
    mode_q <= mode;
  end

  assign flush = !rst && (mode != mode_q);
  assign wr_g  = cpu_wr && !bank_sel && !flush;
  assign pop_g = tx_pop && !flush;

  uth_single #(.DATA_W(DATA_W)) u_single (
    .clk(clk), .rst(rst), .flush(flush),
    .wr(wr_g && mode == MODE_SINGLE), .wdata(cpu_wdata),
    .pop(pop_g && mode == MODE_SINGLE),
    .valid(s_valid), .rdata(s_data)
  );

  uth_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush),
    .wr(wr_g && mode == MODE_QUEUE), .wdata(cpu_wdata),
    .pop(pop_g && mode == MODE_QUEUE),
    .valid(q_valid), .rdata(q_data)
  );

  assign tx_valid   = (mode == MODE_QUEUE) ? q_valid : s_valid;
  assign tx_data    = (mode == MODE_QUEUE) ? q_data  : s_data;
  assign hold_empty = !tx_valid;

  assert_bank_block_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && bank_sel && hold_empty && !flush) |=> hold_empty);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> hold_empty);
endmodule

// File: tb/sim_uart_tx_hold.sv
module sim_uart_tx_hold;
  logic       clk = 1'b0;
  logic       rst, fifo_on, bank_sel, cpu_wr, tx_pop;
  logic [7:0] cpu_wdata, tx_data;
  logic       tx_valid, hold_empty;

  int n_vec  = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  uart_tx_hold u0 (
    .clk(clk), .rst(rst), .fifo_on(fifo_on), .bank_sel(bank_sel),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .tx_pop(tx_pop),
    .tx_valid(tx_valid), .tx_data(tx_data), .hold_empty(hold_empty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor side: compare status and head of queue against the scoreboard.
  task automatic monitor(input string req);
    check({req, " empty"}, hold_empty, exp_q.size() == 0);
    check({req, " valid"}, tx_valid, exp_q.size() != 0);
    if (exp_q.size() != 0) check({req, " data"}, tx_data, exp_q[0]);
  endtask

  // Driver: one cycle of stimulus; updates the scoreboard per the requirements.
  task automatic step(input logic w, input logic [7:0] d, input logic p, input logic b);
    cpu_wr = w; cpu_wdata = d; tx_pop = p; bank_sel = b;
    if (p && exp_q.size() != 0) void'(exp_q.pop_front());
    if (w && !b) begin
      if (fifo_on) begin
        if (exp_q.size() < 16) exp_q.push_back(d);
      end else begin
        exp_q.delete();
        exp_q.push_back(d);
      end
    end
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0; tx_pop = 1'b0; bank_sel = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; fifo_on = 1'b0; bank_sel = 1'b0; cpu_wr = 1'b0;
    cpu_wdata = 8'h00; tx_pop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    monitor("R1");

    // Single mode
    step(1, 8'hA5, 0, 0); monitor("R3");
    step(0, 0, 1, 0);     monitor("R10");
    step(1, 8'h11, 0, 0);
    step(1, 8'h22, 0, 0); monitor("R3");
    step(0, 0, 1, 0);     monitor("R7");
    step(0, 0, 1, 0);     monitor("R9");
    step(1, 8'h77, 0, 1); monitor("R2");
    step(1, 8'h33, 0, 0);
    step(1, 8'h44, 1, 0); monitor("R3");
    step(0, 0, 1, 0);     monitor("R7");

    // Switch to queue mode
    fifo_on = 1'b1; exp_q.delete();
    step(0, 0, 0, 0);     monitor("R8");
    for (int i = 0; i < 16; i++) step(1, 8'(8'h40 + i), 0, 0);
    monitor("R4");
    step(1, 8'hEE, 0, 0); monitor("R5");
    step(1, 8'hEF, 0, 1); monitor("R2");
    step(1, 8'h99, 1, 0); monitor("R6");
    for (int i = 0; i < 16; i++) step(0, 0, 1, 0);
    monitor("R4");
    check("R4 drained", hold_empty, 1'b1);
    step(0, 0, 1, 0);     monitor("R9");

    step(1, 8'h5A, 0, 0);
    step(1, 8'h6B, 0, 0); monitor("R4");

    // Flip mode with data pending and a write in the flip cycle
    fifo_on = 1'b0; exp_q.delete();
    cpu_wr = 1'b1; cpu_wdata = 8'hCC;
    @(posedge clk); @(negedge clk); cpu_wr = 1'b0;
    monitor("R8");
    check("R8 flushed", hold_empty, 1'b1);
    step(1, 8'hD1, 0, 0); monitor("R3");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule